// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns a demodulated, already synchronized infrared receiver level into decoded remote-control frames. The level is sampled on a sample-rate enable tick. The block measures, in sample ticks, the spacing between the starts of successive marks. It sorts each spacing into one of four classes using a symmetric tolerance band: frame leader, repeat code, logic zero or logic one. A field sequencer then gathers the address and command bits, checks the inverted copies, and publishes the result once the trailing stop mark ends.

All timing constants are derived at elaboration from the sample rate, the tolerance percentage and the nominal durations in microseconds. A mode pin selects between an 8-bit address that is followed by its inverted copy and a 16-bit address that has no inverted copy. A failed inverse check is reported in a flag, and the frame is still completed. A spacing that fits no bit class aborts the frame. A long quiet period returns the sequencer to idle, except while it waits for the stop mark to end.

Top module: `ir_pulse_frame_decoder`

## Requirements
- R1: After reset, `frame_valid`, `rpt_strobe` and `frame_err` are low, and `addr_out`, `cmd_out`, `addr_chk_fail` and `cmd_chk_fail` are all zero.
- R2: A spacing is measured as the number of sample ticks between two mark starts, minus one. Clock cycles without `smp_tick` do not count. The nominal count for a duration is floor(rate × duration) − 1. The durations are 13.5 ms (leader), 11.25 ms (repeat), 1.125 ms (zero) and 2.25 ms (one). A spacing matches a class when it lies between ceil(base × (100 − TOL)/100) and floor(base × (100 + TOL)/100), both inclusive. The leader class wins over the repeat class.
- R3: In 8-bit mode (`wide_addr` = 0) the fields arrive in this order: address byte, inverted address byte, command byte, inverted command byte. Each byte is sent least-significant bit first. On the falling edge that ends the stop mark, `frame_valid` pulses for one clock. In the same cycle, `addr_out` shows {8'h00, address} and `cmd_out` shows the command.
- R4: When an inverted byte is not the bitwise complement of its partner, the frame still completes. The matching flag `addr_chk_fail` or `cmd_chk_fail` is then 1 alongside that frame's `frame_valid`, and the other flag is 0.
- R5: With `wide_addr` = 1, the first field is 16 bits sent least-significant bit first, and the command field follows directly. `addr_out` carries all 16 bits, and `addr_chk_fail` is 0.
- R6: In idle, a repeat-class spacing pulses `rpt_strobe` for one clock and produces no frame.
- R7: A spacing inside any data field that matches neither bit class pulses `frame_err`, discards the frame and returns to idle.
- R8: When the measured spacing reaches the idle limit (floor(rate × 20 ms) − 1) in any data field, the frame is dropped without `frame_err` or `frame_valid`. While the decoder waits for the stop mark to end, there is no timeout.
- R9: `addr_out`, `cmd_out` and both check flags change only together with a `frame_valid` pulse. Repeats, errors and timeouts leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_tick | input | 1 | Sample-rate enable; `ir_mark` is sampled only when it is high |
| ir_mark | input | 1 | Demodulated level, 1 while carrier is present |
| wide_addr | input | 1 | 1 selects the 16-bit address without an inverted copy |
| frame_valid | output | 1 | One-clock pulse when a frame completes |
| rpt_strobe | output | 1 | One-clock pulse on a repeat code |
| frame_err | output | 1 | One-clock pulse when a data spacing fits no bit class |
| addr_out | output | 16 | Address of the last completed frame |
| cmd_out | output | 8 | Command of the last completed frame |
| addr_chk_fail | output | 1 | Inverted address mismatch in the last frame |
| cmd_chk_fail | output | 1 | Inverted command mismatch in the last frame |

## Verification
Address and command bytes with one bit set at several positions confirm the bit order and field placement. Frames with a corrupted inverted byte separate the two check flags, and 16-bit frames show that the inverted-address field is skipped. The first address bit is swept across both edges of the zero and one windows, and the leader length across the edges of its window, including a length that falls into the repeat window. Together these tell acceptance apart from framing errors and from repeat detection. A pause in the middle of a frame and a greatly stretched stop mark show where the idle timeout applies and where it does not.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 16;
   localparam int NUM_CLS = 4;

   // class indices; the leader index is the highest priority
   localparam int CLS_LEADER = 0;
   localparam int CLS_REPEAT = 1;
   localparam int CLS_ZERO   = 2;
   localparam int CLS_ONE    = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_INV,
      ST_CMD,
      ST_CMD_INV,
      ST_STOP
   } dec_state_t;

   function automatic int us_to_count(input int rate_hz, input int dur_us);
      longint prod;
      prod = longint'(rate_hz) * longint'(dur_us);
      return int'(prod / longint'(1000000)) - 1;
   endfunction

   function automatic int win_lo(input int base, input int tol_pct);
      return (base * (100 - tol_pct) + 99) / 100;
   endfunction

   function automatic int win_hi(input int base, input int tol_pct);
      return (base * (100 + tol_pct)) / 100;
   endfunction

endpackage

// File: rtl/irdec_edge_timer.sv
module irdec_edge_timer #(
   parameter int CW    = 11,
   parameter int LIMIT = 1999
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_tick,
   input  logic          ir_mark,
   output logic          rise_o,
   output logic          fall_o,
   output logic [CW-1:0] span_o,
   output logic          stale_o
);
   localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

   logic          mark_q;
   logic [CW-1:0] span_q;

   assign rise_o  = smp_tick & ir_mark & ~mark_q;
   assign fall_o  = smp_tick & ~ir_mark & mark_q;
   assign span_o  = span_q;
   assign stale_o = (span_q == LIMIT_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_q <= 1'b0;
         span_q <= LIMIT_V;
      end else if (smp_tick) begin
         mark_q <= ir_mark;
         if (rise_o)
            span_q <= '0;
         else if (span_q != LIMIT_V)
            span_q <= span_q + CW'(1);
      end
   end

   // R2
   span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_tick |=> $stable(span_q));

   // R2
   span_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> (span_q == '0));

   // R8
   span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      span_q <= LIMIT_V);

endmodule

// File: rtl/irdec_window.sv
module irdec_window #(
   parameter int CW = 11,
   parameter int LO = 0,
   parameter int HI = 1
) (
   input  logic [CW-1:0] span_i,
   output logic          hit_o
);
   localparam logic [CW-1:0] LO_V = CW'(LO);
   localparam logic [CW-1:0] HI_V = CW'(HI);

   assign hit_o = (span_i >= LO_V) && (span_i <= HI_V);

endmodule

// File: rtl/irdec_frame_fsm.sv
module irdec_frame_fsm
   import irdec_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rise_i,
   input  logic                  fall_i,
   input  logic                  stale_i,
   input  logic [NUM_CLS-1:0]    hit_i,
   input  logic                  wide_i,
   output logic                  frame_valid_o,
   output logic                  rpt_o,
   output logic                  frame_err_o,
   output logic [ADDR_W-1:0]     addr_o,
   output logic [BYTE_W-1:0]     cmd_o,
   output logic                  addr_bad_o,
   output logic                  cmd_bad_o
);
   localparam int NB = $clog2(ADDR_W);

   dec_state_t        st_q, st_d;
   logic [NB-1:0]     nbit_q, nbit_d;
   logic [ADDR_W-1:0] sh_q, sh_d, sh_ins;
   logic [ADDR_W-1:0] addr_w_q, addr_w_d;
   logic [BYTE_W-1:0] cmd_w_q, cmd_w_d;
   logic              abad_w_q, abad_w_d, cbad_w_q, cbad_w_d;
   logic              fv_d, rpt_d, ferr_d;
   logic              bit_ok, last_bit;
   logic [NB-1:0]     len_m1;

   assign bit_ok   = hit_i[CLS_ZERO] | hit_i[CLS_ONE];
   assign len_m1   = (st_q == ST_ADDR && wide_i) ? NB'(ADDR_W - 1) : NB'(BYTE_W - 1);
   assign last_bit = (nbit_q == len_m1);
   assign sh_ins   = sh_q | (ADDR_W'(hit_i[CLS_ONE]) << nbit_q);

   always_comb begin
      st_d     = st_q;
      nbit_d   = nbit_q;
      sh_d     = sh_q;
      addr_w_d = addr_w_q;
      cmd_w_d  = cmd_w_q;
      abad_w_d = abad_w_q;
      cbad_w_d = cbad_w_q;
      fv_d     = 1'b0;
      rpt_d    = 1'b0;
      ferr_d   = 1'b0;
      if (stale_i && st_q != ST_IDLE && st_q != ST_STOP) begin
         st_d   = ST_IDLE;
         nbit_d = '0;
         sh_d   = '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (rise_i) begin
                  if (hit_i[CLS_LEADER]) begin
                     st_d     = ST_ADDR;
                     nbit_d   = '0;
                     sh_d     = '0;
                     abad_w_d = 1'b0;
                     cbad_w_d = 1'b0;
                  end else if (hit_i[CLS_REPEAT]) begin
                     rpt_d = 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (fall_i) begin
                  fv_d = 1'b1;
                  st_d = ST_IDLE;
               end
            end
            default: begin
               if (rise_i) begin
                  if (!bit_ok) begin
                     ferr_d = 1'b1;
                     st_d   = ST_IDLE;
                     nbit_d = '0;
                     sh_d   = '0;
                  end else if (!last_bit) begin
                     sh_d   = sh_ins;
                     nbit_d = nbit_q + NB'(1);
                  end else begin
                     nbit_d = '0;
                     sh_d   = '0;
                     case (st_q)
                        ST_ADDR: begin
                           addr_w_d = wide_i ? sh_ins : {{(ADDR_W-BYTE_W){1'b0}}, sh_ins[BYTE_W-1:0]};
                           st_d     = wide_i ? ST_CMD : ST_ADDR_INV;
                        end
                        ST_ADDR_INV: begin
                           abad_w_d = (sh_ins[BYTE_W-1:0] != ~addr_w_q[BYTE_W-1:0]);
                           st_d     = ST_CMD;
                        end
                        ST_CMD: begin
                           cmd_w_d = sh_ins[BYTE_W-1:0];
                           st_d    = ST_CMD_INV;
                        end
                        default: begin
                           cbad_w_d = (sh_ins[BYTE_W-1:0] != ~cmd_w_q);
                           st_d     = ST_STOP;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         nbit_q        <= '0;
         sh_q          <= '0;
         addr_w_q      <= '0;
         cmd_w_q       <= '0;
         abad_w_q      <= 1'b0;
         cbad_w_q      <= 1'b0;
         frame_valid_o <= 1'b0;
         rpt_o         <= 1'b0;
         frame_err_o   <= 1'b0;
         addr_o        <= '0;
         cmd_o         <= '0;
         addr_bad_o    <= 1'b0;
         cmd_bad_o     <= 1'b0;
      end else begin
         st_q          <= st_d;
         nbit_q        <= nbit_d;
         sh_q          <= sh_d;
         addr_w_q      <= addr_w_d;
         cmd_w_q       <= cmd_w_d;
         abad_w_q      <= abad_w_d;
         cbad_w_q      <= cbad_w_d;
         frame_valid_o <= fv_d;
         rpt_o         <= rpt_d;
         frame_err_o   <= ferr_d;
         if (fv_d) begin
            addr_o     <= addr_w_q;
            cmd_o      <= cmd_w_q;
            addr_bad_o <= abad_w_q;
            cmd_bad_o  <= cbad_w_q;
         end
      end
   end

   // R3
   fv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |=> !frame_valid_o);

   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid_o |-> ($stable(addr_o) && $stable(cmd_o) && $stable(addr_bad_o) && $stable(cmd_bad_o)));

   // R8
   idle_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stale_i && st_q != ST_STOP) |=> (st_q == ST_IDLE));

   // R6
   rpt_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_o |-> ($past(st_q) == ST_IDLE && st_q == ST_IDLE && !frame_valid_o));

   // R7
   ferr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> (st_q == ST_IDLE && !frame_valid_o));

   // R5
   wide_no_chk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ADDR && wide_i && rise_i && bit_ok && last_bit && !stale_i) |=> (st_q == ST_CMD));

endmodule

// File: rtl/ir_pulse_frame_decoder.sv
module ir_pulse_frame_decoder
   import irdec_pkg::*;
#(
   parameter int SAMPLE_HZ = 100000,
   parameter int TOL_PCT   = 15,
   parameter int LEADER_US = 13500,
   parameter int REPEAT_US = 11250,
   parameter int ZERO_US   = 1125,
   parameter int ONE_US    = 2250,
   parameter int IDLE_US   = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_tick,
   input  logic              ir_mark,
   input  logic              wide_addr,
   output logic              frame_valid,
   output logic              rpt_strobe,
   output logic              frame_err,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BYTE_W-1:0] cmd_out,
   output logic              addr_chk_fail,
   output logic              cmd_chk_fail
);
   localparam int IDLE_CNT = us_to_count(SAMPLE_HZ, IDLE_US);
   localparam int CW       = $clog2(IDLE_CNT + 1);
   localparam int CLS_US [NUM_CLS] = '{LEADER_US, REPEAT_US, ZERO_US, ONE_US};
   localparam int LEAD_HI  = win_hi(us_to_count(SAMPLE_HZ, LEADER_US), TOL_PCT);
   localparam int ZERO_HI  = win_hi(us_to_count(SAMPLE_HZ, ZERO_US), TOL_PCT);
   localparam int ONE_LO   = win_lo(us_to_count(SAMPLE_HZ, ONE_US), TOL_PCT);
   localparam int ZERO_LO  = win_lo(us_to_count(SAMPLE_HZ, ZERO_US), TOL_PCT);

   generate
      if (TOL_PCT < 1 || TOL_PCT > 30) begin : g_bad_tol
         $error("tolerance percentage must lie in 1..30");
      end
      if (LEAD_HI >= IDLE_CNT) begin : g_bad_idle
         $error("idle limit must exceed the leader window");
      end
      if (ZERO_HI >= ONE_LO || ZERO_LO < 1) begin : g_bad_bits
         $error("bit windows overlap or sample rate too low");
      end
   endgenerate

   logic          rise, fall, stale;
   logic [CW-1:0] span;
   logic [NUM_CLS-1:0] hit;

   irdec_edge_timer #(
      .CW    (CW),
      .LIMIT (IDLE_CNT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_tick (smp_tick),
      .ir_mark  (ir_mark),
      .rise_o   (rise),
      .fall_o   (fall),
      .span_o   (span),
      .stale_o  (stale)
   );

   for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
      localparam int BASE = us_to_count(SAMPLE_HZ, CLS_US[k]);
      irdec_window #(
         .CW (CW),
         .LO (win_lo(BASE, TOL_PCT)),
         .HI (win_hi(BASE, TOL_PCT))
      ) u_win (
         .span_i (span),
         .hit_o  (hit[k])
      );
   end

   irdec_frame_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .rise_i        (rise),
      .fall_i        (fall),
      .stale_i       (stale),
      .hit_i         (hit),
      .wide_i        (wide_addr),
      .frame_valid_o (frame_valid),
      .rpt_o         (rpt_strobe),
      .frame_err_o   (frame_err),
      .addr_o        (addr_out),
      .cmd_o         (cmd_out),
      .addr_bad_o    (addr_chk_fail),
      .cmd_bad_o     (cmd_chk_fail)
   );

   // R1
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frame_valid, rpt_strobe, frame_err}));

endmodule

// File: tb/ir_pulse_frame_decoder_tb.sv
module ir_pulse_frame_decoder_tb;
   localparam int RATE = 20000;
   localparam int TOL  = 10;

   // nominal counts and windows from R2
   localparam int B_LEAD = RATE * 13500 / 1000000 - 1;
   localparam int B_REP  = RATE * 11250 / 1000000 - 1;
   localparam int B_ZERO = RATE * 1125 / 1000000 - 1;
   localparam int B_ONE  = RATE * 2250 / 1000000 - 1;
   localparam int S_ZERO = B_ZERO + 1;
   localparam int S_ONE  = B_ONE + 1;
   localparam int S_LEAD = B_LEAD + 1;
   localparam int S_REP  = B_REP + 1;
   localparam int MARK   = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_tick = 1'b0;
   logic ir_mark = 1'b0;
   logic wide_sel = 1'b0;
   logic frame_valid, rpt_strobe, frame_err, addr_chk_fail, cmd_chk_fail;
   logic [15:0] addr_out;
   logic [7:0]  cmd_out;

   int n_chk = 0;
   int n_err = 0;
   int fv_cnt = 0, rp_cnt = 0, fe_cnt = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2.5ns clk = ~clk;

   ir_pulse_frame_decoder #(.SAMPLE_HZ(RATE), .TOL_PCT(TOL)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .ir_mark(ir_mark),
      .wide_addr(wide_sel), .frame_valid(frame_valid), .rpt_strobe(rpt_strobe),
      .frame_err(frame_err), .addr_out(addr_out), .cmd_out(cmd_out),
      .addr_chk_fail(addr_chk_fail), .cmd_chk_fail(cmd_chk_fail)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_valid) fv_cnt++;
         if (rpt_strobe)  rp_cnt++;
         if (frame_err)   fe_cnt++;
      end
   end

   function automatic int ceil_pct(input int b, input int p);
      return (b * p + 99) / 100;
   endfunction

   function automatic bit in_win(input int meas, input int b);
      return meas >= ceil_pct(b, 100 - TOL) && meas <= (b * (100 + TOL)) / 100;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic smp(input logic lvl);
      ir_mark = lvl;
      smp_tick = 1'b1;
      @(negedge clk);
      smp_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic hold(input logic lvl, input int n);
      for (int i = 0; i < n; i++) smp(lvl);
   endtask

   task automatic span(input int total, input int mk);
      hold(1'b1, mk);
      hold(1'b0, total - mk);
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      for (int i = 0; i < n; i++) span(v[i] ? S_ONE : S_ZERO, MARK);
   endtask

   task automatic send_tail(input logic [7:0] ai, input logic [7:0] c, input logic [7:0] ci, input int stop_len);
      send_bits({8'h00, ai}, 8);
      send_bits({8'h00, c}, 8);
      send_bits({8'h00, ci}, 8);
      hold(1'b1, stop_len);
      hold(1'b0, 60);
   endtask

   task automatic send_frame(input logic [15:0] a, input logic [7:0] ai, input logic [7:0] c,
                             input logic [7:0] ci, input int stop_len);
      span(S_LEAD, 180);
      if (wide_sel) begin
         send_bits(a, 16);
         send_bits({8'h00, c}, 8);
         send_bits({8'h00, ci}, 8);
         hold(1'b1, stop_len);
         hold(1'b0, 60);
      end else begin
         send_bits(a, 8);
         send_tail(ai, c, ci, stop_len);
      end
   endtask

   task automatic expect_frame(input string tag, input int fv0, input logic [15:0] a, input logic [7:0] c,
                               input logic ab, input logic cb);
      check({tag, " frame count"}, fv_cnt - fv0, 1);
      check({tag, " addr"}, addr_out, a);
      check({tag, " cmd"}, cmd_out, c);
      check({tag, " addr flag"}, addr_chk_fail, ab);
      check({tag, " cmd flag"}, cmd_chk_fail, cb);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int fv0, rp0, fe0;
      logic [7:0] a8, c8;
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 frame_valid", frame_valid, 0);
      check("R1 rpt_strobe", rpt_strobe, 0);
      check("R1 frame_err", frame_err, 0);
      check("R1 addr", addr_out, 0);
      check("R1 cmd", cmd_out, 0);
      check("R1 flags", {addr_chk_fail, cmd_chk_fail}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 basic frame
      fv0 = fv_cnt;
      send_frame(16'h002D, 8'hD2, 8'h96, 8'h69, MARK);
      expect_frame("R3 basic", fv0, 16'h002D, 8'h96, 1'b0, 1'b0);

      // R3 bit order with single set bits
      for (int k = 0; k < 4; k++) begin
         a8 = 8'h01 << (2 * k);
         c8 = 8'h80 >> k;
         fv0 = fv_cnt;
         send_frame({8'h00, a8}, ~a8, c8, ~c8, MARK);
         expect_frame("R3 walk", fv0, {8'h00, a8}, c8, 1'b0, 1'b0);
      end

      // R4 inverse mismatches
      fv0 = fv_cnt;
      send_frame(16'h0010, 8'h00, 8'h21, 8'hDE, MARK);
      expect_frame("R4 addr inverse", fv0, 16'h0010, 8'h21, 1'b1, 1'b0);
      fv0 = fv_cnt;
      send_frame(16'h0044, 8'hBB, 8'h44, 8'h44, MARK);
      expect_frame("R4 cmd inverse", fv0, 16'h0044, 8'h44, 1'b0, 1'b1);

      // R5 wide address
      wide_sel = 1'b1;
      fv0 = fv_cnt;
      send_frame(16'hA55A, 8'h00, 8'h5E, 8'hA1, MARK);
      expect_frame("R5 wide", fv0, 16'hA55A, 8'h5E, 1'b0, 1'b0);
      fv0 = fv_cnt;
      send_frame(16'h8001, 8'h00, 8'h07, 8'hF8, MARK);
      expect_frame("R5 wide msb", fv0, 16'h8001, 8'h07, 1'b0, 1'b0);
      wide_sel = 1'b0;

      // R6 repeat code, R9 outputs held
      fv0 = fv_cnt; rp0 = rp_cnt;
      span(S_REP, 180);
      hold(1'b1, MARK);
      hold(1'b0, 60);
      check("R6 repeat strobe", rp_cnt - rp0, 1);
      check("R6 no frame", fv_cnt - fv0, 0);
      check("R9 addr held", addr_out, 16'h8001);
      check("R9 cmd held", cmd_out, 8'h07);

      // R2 and R7 sweep of the first address bit spacing
      for (int n = S_ZERO - 5; n <= S_ONE + 6; n++) begin
         if (n > S_ZERO + 5 && n < S_ONE - 6) continue;
         fv0 = fv_cnt; fe0 = fe_cnt;
         span(S_LEAD, 180);
         span(n, MARK);
         send_bits(16'h0000, 7);
         if (in_win(n - 1, B_ONE)) send_tail(8'hFE, 8'h3C, 8'hC3, MARK);
         else send_tail(8'hFF, 8'h3C, 8'hC3, MARK);
         if (in_win(n - 1, B_ZERO) || in_win(n - 1, B_ONE)) begin
            check("R2 bit accepted", fv_cnt - fv0, 1);
            check("R2 bit value", addr_out, in_win(n - 1, B_ONE) ? 1 : 0);
            check("R2 no error", fe_cnt - fe0, 0);
         end else begin
            check("R7 framing error", fe_cnt - fe0, 1);
            check("R7 frame dropped", fv_cnt - fv0, 0);
         end
      end

      // R2 leader window edges; below it falls into the repeat window
      for (int j = 0; j < 4; j++) begin
         int len;
         len = (j == 0) ? ceil_pct(B_LEAD, 100 - TOL) :
               (j == 1) ? ceil_pct(B_LEAD, 100 - TOL) + 1 :
               (j == 2) ? (B_LEAD * (100 + TOL)) / 100 + 1 :
                          (B_LEAD * (100 + TOL)) / 100 + 2;
         fv0 = fv_cnt; rp0 = rp_cnt;
         span(len, 180);
         send_bits(16'h0033, 8);
         send_tail(8'hCC, 8'h0F, 8'hF0, MARK);
         check("R2 leader accept", fv_cnt - fv0, in_win(len - 1, B_LEAD) ? 1 : 0);
         check("R6 leader vs repeat", rp_cnt - rp0,
               (!in_win(len - 1, B_LEAD) && in_win(len - 1, B_REP)) ? 1 : 0);
      end

      // R8 timeout mid frame
      fv0 = fv_cnt; fe0 = fe_cnt;
      span(S_LEAD, 180);
      send_bits(16'h0055, 8);
      send_bits(16'h0002, 2);
      hold(1'b0, 420);
      send_bits(16'h0000, 6);
      send_tail(8'h12, 8'h34, 8'h56, MARK);
      check("R8 timeout no frame", fv_cnt - fv0, 0);
      check("R8 timeout no error", fe_cnt - fe0, 0);
      check("R9 held after timeout", addr_out, 16'h0033);

      // R8 no timeout while waiting for the stop mark to end
      fv0 = fv_cnt;
      send_frame(16'h00C8, 8'h37, 8'h19, 8'hE6, 500);
      expect_frame("R8 long stop", fv0, 16'h00C8, 8'h19, 1'b0, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule